// File: doc/BRIEF.md
# Flash Operation Permission Checker

This block stands in front of a flash memory controller and rules on every requested operation before it reaches the array. A request names an operation, a partition, a bank, a page and a program-type select. The block answers with a response one clock later. The response always completes, so a poller waiting for the operation to finish never stalls. It also says whether the operation may proceed. On a denial the block records the cause in a sticky error-code register and pulses a recoverable-alert request.

Three separate gates decide a request. The first is a two-bit program-type enable, which applies to program requests only. For data-partition pages, a set of page-range protection regions applies, with a default region as the fallback. For info-partition pages, the block uses one permission entry per bank, per info type and per page. Whole-bank erase has a per-bank enable of its own. Each permission field is a 4-bit multi-bit boolean, and only one exact encoding counts as true.

Top module: `flash_perm_guard`

## Requirements
- R1: Every cycle with `reqValid` high produces `respValid` high on the next cycle, whether the request is allowed or denied. A cycle without a request gives `respValid` low on the next cycle, and `respAllow` is then also low.
- R2: A program request (`reqOp`=1) is denied when `progTypeEn[reqProgSel]` is 0. Bit 0 of the enable is normal programming (select 0) and bit 1 is repair programming (select 1). Such a denial sets `errCode[1]`, and this check takes precedence over the page permission checks.
- R3: A 4-bit permission field counts as true only when it equals 4'b0110. Any other value counts as false and does not permit the operation.
- R4: A data-partition request (`reqInfo`=0) looks up the global page {reqBank, reqPage}. A region matches when its enable field is true and start <= page < start+count. A region with a count of zero matches nothing. When several regions match, the lowest-indexed one decides.
- R5: When no region matches a data-partition page, the default region's read, program and erase fields decide.
- R6: Operation encodings: 0 is read, checked against the read field. 1 is program, checked against the program field. 2 is page erase, checked against the erase field. 3 is bank erase.
- R7: A bank erase (`reqOp`=3) is allowed exactly when `bankEraseEn[reqBank]` is 1, whatever the partition, regions or info entries say.
- R8: An info-partition request (`reqInfo`=1) uses entry ((bank*INFO_TYPES + infoType)*INFO_PAGES + page). It is allowed only when that entry's enable field and operation field are both true. A page at or above INFO_PAGES is denied.
- R9: A request denied by a permission field, and not by the program-type check, sets `errCode[0]`.
- R10: Both `errCode` bits are sticky. Writing 1 to a bit of `errClr` clears that bit. If a set and a clear reach the same bit in the same cycle, the set wins.
- R11: `alertReq` is high for exactly the cycles in which a response reports a denial, which is one pulse per denied request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | Operation: 0 read, 1 program, 2 page erase, 3 bank erase |
| reqInfo | input | 1 | Partition: 0 data, 1 info |
| reqBank | input | BANK_W | Bank number |
| reqPage | input | PAGE_W | Page within the bank |
| reqInfoType | input | TYPE_W | Info type (info partition only) |
| reqProgSel | input | 1 | Program type: 0 normal, 1 repair |
| progTypeEn | input | 2 | Program-type enables (bit0 normal, bit1 repair) |
| regEnCfg | input | NUM_REGIONS*4 | Region enable fields |
| regRdCfg | input | NUM_REGIONS*4 | Region read fields |
| regProgCfg | input | NUM_REGIONS*4 | Region program fields |
| regEraseCfg | input | NUM_REGIONS*4 | Region erase fields |
| regStartCfg | input | NUM_REGIONS*G_W | Region start global page |
| regCountCfg | input | NUM_REGIONS*(G_W+1) | Region page count |
| dfltRdCfg | input | 4 | Default region read field |
| dfltProgCfg | input | 4 | Default region program field |
| dfltEraseCfg | input | 4 | Default region erase field |
| bankEraseEn | input | NUM_BANKS | Per-bank whole-erase enable |
| infoEnCfg | input | NUM_INFO*4 | Info entry enable fields |
| infoRdCfg | input | NUM_INFO*4 | Info entry read fields |
| infoProgCfg | input | NUM_INFO*4 | Info entry program fields |
| infoEraseCfg | input | NUM_INFO*4 | Info entry erase fields |
| errClr | input | 2 | Write-1-to-clear strobes for errCode |
| respValid | output | 1 | Response (operation done) |
| respAllow | output | 1 | Operation permitted |
| errCode | output | 2 | Sticky errors: bit0 protection, bit1 program type |
| alertReq | output | 1 | Recoverable-alert pulse |

## Verification
The decision, the error-code update and the alert all come out of a single register stage. Each result therefore appears on the clock edge right after the edge that captured the request or the clear. The bench drives each request on a falling edge and drops it on the next falling edge. It reads all four outputs at that second falling edge, which falls half a cycle after the edge that loaded them. Idle cycles with only a clear are checked the same way. This shows that the response stays low when no request is present and that the clear acts on the following edge.

// File: rtl/flash_perm_pkg.sv
package flash_perm_pkg;

  localparam logic [3:0] MUBI_TRUE = 4'b0110;

  typedef enum logic [1:0] {
    OP_READ       = 2'd0,
    OP_PROG       = 2'd1,
    OP_PAGE_ERASE = 2'd2,
    OP_BANK_ERASE = 2'd3
  } flashOp_e;

  // Result of the permission lookup
  typedef struct packed {
    logic permOk;
    logic typeOk;
  } verdict_t;

  // Strobes from the decision logic to the response registers
  typedef struct packed {
    logic done;
    logic allow;
    logic setMp;
    logic setPt;
  } strobes_t;

  function automatic logic mubiTrue(input logic [3:0] v);
    return v == MUBI_TRUE;
  endfunction

endpackage

// File: rtl/flash_perm_lookup.sv
module flash_perm_lookup
  import flash_perm_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_BANKS   = 2,
  parameter int PAGE_W      = 5,
  parameter int INFO_TYPES  = 2,
  parameter int INFO_PAGES  = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int TYPE_W   = (INFO_TYPES > 1) ? $clog2(INFO_TYPES) : 1,
  localparam int G_W      = BANK_W + PAGE_W,
  localparam int NUM_INFO = NUM_BANKS * INFO_TYPES * INFO_PAGES
) (
  input  logic [1:0]                   reqOp,
  input  logic                         reqInfo,
  input  logic [BANK_W-1:0]            reqBank,
  input  logic [PAGE_W-1:0]            reqPage,
  input  logic [TYPE_W-1:0]            reqInfoType,
  input  logic                         reqProgSel,
  input  logic [1:0]                   progTypeEn,
  input  logic [NUM_REGIONS*4-1:0]     regEnCfg,
  input  logic [NUM_REGIONS*4-1:0]     regRdCfg,
  input  logic [NUM_REGIONS*4-1:0]     regProgCfg,
  input  logic [NUM_REGIONS*4-1:0]     regEraseCfg,
  input  logic [NUM_REGIONS*G_W-1:0]   regStartCfg,
  input  logic [NUM_REGIONS*(G_W+1)-1:0] regCountCfg,
  input  logic [3:0]                   dfltRdCfg,
  input  logic [3:0]                   dfltProgCfg,
  input  logic [3:0]                   dfltEraseCfg,
  input  logic [NUM_BANKS-1:0]         bankEraseEn,
  input  logic [NUM_INFO*4-1:0]        infoEnCfg,
  input  logic [NUM_INFO*4-1:0]        infoRdCfg,
  input  logic [NUM_INFO*4-1:0]        infoProgCfg,
  input  logic [NUM_INFO*4-1:0]        infoEraseCfg,
  output verdict_t                     verdict
);

  logic [G_W-1:0]         gPage;
  logic [NUM_REGIONS-1:0] regHit;

  assign gPage = {reqBank, reqPage};

  // One range comparator per region, two guard bits against carry-out
  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    logic [G_W+1:0] lo;
    logic [G_W+1:0] span;
    logic [G_W+1:0] pg;
    assign lo   = {2'b00, regStartCfg[i*G_W +: G_W]};
    assign span = lo + {1'b0, regCountCfg[i*(G_W+1) +: G_W+1]};
    assign pg   = {2'b00, gPage};
    assign regHit[i] = mubiTrue(regEnCfg[i*4 +: 4]) && (pg >= lo) && (pg < span);
  end

  // Lowest matching index wins: scan from the top down
  logic [3:0] selRd, selProg, selErase;
  always_comb begin
    selRd    = dfltRdCfg;
    selProg  = dfltProgCfg;
    selErase = dfltEraseCfg;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (regHit[i]) begin
        selRd    = regRdCfg[i*4 +: 4];
        selProg  = regProgCfg[i*4 +: 4];
        selErase = regEraseCfg[i*4 +: 4];
      end
    end
  end

  // Info-partition entry lookup
  logic       infoInRange;
  int         infoIdx;
  logic [3:0] iEn, iRd, iProg, iErase;
  always_comb begin
    infoInRange = (int'(reqPage) < INFO_PAGES) && (int'(reqInfoType) < INFO_TYPES) &&
                  (int'(reqBank) < NUM_BANKS);
    infoIdx = infoInRange ?
              ((int'(reqBank) * INFO_TYPES + int'(reqInfoType)) * INFO_PAGES + int'(reqPage)) : 0;
    iEn    = infoEnCfg[infoIdx*4 +: 4];
    iRd    = infoRdCfg[infoIdx*4 +: 4];
    iProg  = infoProgCfg[infoIdx*4 +: 4];
    iErase = infoEraseCfg[infoIdx*4 +: 4];
  end

  logic [3:0] dataField, infoField;
  always_comb begin
    case (reqOp)
      OP_READ: begin
        dataField = selRd;
        infoField = iRd;
      end
      OP_PROG: begin
        dataField = selProg;
        infoField = iProg;
      end
      default: begin
        dataField = selErase;
        infoField = iErase;
      end
    endcase
  end

  always_comb begin
    if (reqOp == OP_BANK_ERASE) begin
      verdict.permOk = bankEraseEn[reqBank];
    end else if (reqInfo) begin
      verdict.permOk = infoInRange && mubiTrue(iEn) && mubiTrue(infoField);
    end else begin
      verdict.permOk = mubiTrue(dataField);
    end
    verdict.typeOk = progTypeEn[reqProgSel];
  end

endmodule

// File: rtl/flash_perm_ctrl.sv
module flash_perm_ctrl
  import flash_perm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  verdict_t   verdict,
  input  logic [1:0] errClr,
  output logic       respValid,
  output logic       respAllow,
  output logic [1:0] errCode,
  output logic       alertReq
);

  strobes_t stb;
  logic     denyType;
  logic     denyPerm;

  always_comb begin
    denyType  = (reqOp == OP_PROG) && !verdict.typeOk;
    denyPerm  = !denyType && !verdict.permOk;
    stb.done  = reqValid;
    stb.allow = reqValid && !denyType && !denyPerm;
    stb.setPt = reqValid && denyType;
    stb.setMp = reqValid && denyPerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respAllow <= 1'b0;
      alertReq  <= 1'b0;
      errCode   <= 2'b00;
    end else begin
      respValid <= stb.done;
      respAllow <= stb.allow;
      alertReq  <= stb.setPt | stb.setMp;
      errCode   <= (errCode & ~errClr) | {stb.setPt, stb.setMp};
    end
  end

endmodule

// File: rtl/flash_perm_guard.sv
module flash_perm_guard
  import flash_perm_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_BANKS   = 2,
  parameter int PAGE_W      = 5,
  parameter int INFO_TYPES  = 2,
  parameter int INFO_PAGES  = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int TYPE_W   = (INFO_TYPES > 1) ? $clog2(INFO_TYPES) : 1,
  localparam int G_W      = BANK_W + PAGE_W,
  localparam int NUM_INFO = NUM_BANKS * INFO_TYPES * INFO_PAGES
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic [1:0]                     reqOp,
  input  logic                           reqInfo,
  input  logic [BANK_W-1:0]              reqBank,
  input  logic [PAGE_W-1:0]              reqPage,
  input  logic [TYPE_W-1:0]              reqInfoType,
  input  logic                           reqProgSel,
  input  logic [1:0]                     progTypeEn,
  input  logic [NUM_REGIONS*4-1:0]       regEnCfg,
  input  logic [NUM_REGIONS*4-1:0]       regRdCfg,
  input  logic [NUM_REGIONS*4-1:0]       regProgCfg,
  input  logic [NUM_REGIONS*4-1:0]       regEraseCfg,
  input  logic [NUM_REGIONS*G_W-1:0]     regStartCfg,
  input  logic [NUM_REGIONS*(G_W+1)-1:0] regCountCfg,
  input  logic [3:0]                     dfltRdCfg,
  input  logic [3:0]                     dfltProgCfg,
  input  logic [3:0]                     dfltEraseCfg,
  input  logic [NUM_BANKS-1:0]           bankEraseEn,
  input  logic [NUM_INFO*4-1:0]          infoEnCfg,
  input  logic [NUM_INFO*4-1:0]          infoRdCfg,
  input  logic [NUM_INFO*4-1:0]          infoProgCfg,
  input  logic [NUM_INFO*4-1:0]          infoEraseCfg,
  input  logic [1:0]                     errClr,
  output logic                           respValid,
  output logic                           respAllow,
  output logic [1:0]                     errCode,
  output logic                           alertReq
);

  verdict_t verdict;

  flash_perm_lookup #(
    .NUM_REGIONS(NUM_REGIONS),
    .NUM_BANKS  (NUM_BANKS),
    .PAGE_W     (PAGE_W),
    .INFO_TYPES (INFO_TYPES),
    .INFO_PAGES (INFO_PAGES)
  ) u_lookup (
    .reqOp       (reqOp),
    .reqInfo     (reqInfo),
    .reqBank     (reqBank),
    .reqPage     (reqPage),
    .reqInfoType (reqInfoType),
    .reqProgSel  (reqProgSel),
    .progTypeEn  (progTypeEn),
    .regEnCfg    (regEnCfg),
    .regRdCfg    (regRdCfg),
    .regProgCfg  (regProgCfg),
    .regEraseCfg (regEraseCfg),
    .regStartCfg (regStartCfg),
    .regCountCfg (regCountCfg),
    .dfltRdCfg   (dfltRdCfg),
    .dfltProgCfg (dfltProgCfg),
    .dfltEraseCfg(dfltEraseCfg),
    .bankEraseEn (bankEraseEn),
    .infoEnCfg   (infoEnCfg),
    .infoRdCfg   (infoRdCfg),
    .infoProgCfg (infoProgCfg),
    .infoEraseCfg(infoEraseCfg),
    .verdict     (verdict)
  );

  flash_perm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .verdict  (verdict),
    .errClr   (errClr),
    .respValid(respValid),
    .respAllow(respAllow),
    .errCode  (errCode),
    .alertReq (alertReq)
  );

endmodule

// File: rtl/flash_perm_guard_sva.sv
module flash_perm_guard_sva #(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqOp,
  input logic [BANK_W-1:0] reqBank,
  input logic              reqProgSel,
  input logic [1:0]        progTypeEn,
  input logic [NUM_BANKS-1:0] bankEraseEn,
  input logic [1:0]        errClr,
  input logic              respValid,
  input logic              respAllow,
  input logic [1:0]        errCode,
  input logic              alertReq
);

  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  // R1
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!respValid && !respAllow));

  // R2
  prog_type_deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd1 && !progTypeEn[reqProgSel]) |=> (!respAllow && errCode[1]));

  // R7
  bank_erase_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd3) |=> (respAllow == $past(bankEraseEn[reqBank])));

  // R10
  mp_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCode[0] && !errClr[0]) |=> errCode[0]);

  // R10
  pt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCode[1] && !errClr[1]) |=> errCode[1]);

  // R11
  alert_on_deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respAllow) |-> alertReq);

  // R11
  alert_only_deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    alertReq |-> (respValid && !respAllow));

  // R9
  mp_flag_alert_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errCode[0]) |-> alertReq);

endmodule

bind flash_perm_guard flash_perm_guard_sva #(.NUM_BANKS(NUM_BANKS)) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqOp      (reqOp),
  .reqBank    (reqBank),
  .reqProgSel (reqProgSel),
  .progTypeEn (progTypeEn),
  .bankEraseEn(bankEraseEn),
  .errClr     (errClr),
  .respValid  (respValid),
  .respAllow  (respAllow),
  .errCode    (errCode),
  .alertReq   (alertReq)
);

// File: tb/flash_perm_guard_tb.sv
`timescale 1ns/1ps
module flash_perm_guard_tb;

  localparam int NR  = 4;
  localparam int NB  = 2;
  localparam int PW  = 5;
  localparam int IT  = 2;
  localparam int IP  = 4;
  localparam int GW  = 6;
  localparam int NI  = NB * IT * IP;
  localparam logic [3:0] T = 4'b0110;
  localparam logic [3:0] F = 4'b1001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = '0;
  logic          reqInfo = 1'b0;
  logic          reqBank = 1'b0;
  logic [PW-1:0] reqPage = '0;
  logic          reqInfoType = 1'b0;
  logic          reqProgSel = 1'b0;
  logic [1:0]    progTypeEn = 2'b11;
  logic [NR*4-1:0] regEnCfg = '0, regRdCfg = '0, regProgCfg = '0, regEraseCfg = '0;
  logic [NR*GW-1:0] regStartCfg = '0;
  logic [NR*(GW+1)-1:0] regCountCfg = '0;
  logic [3:0] dfltRdCfg = T, dfltProgCfg = T, dfltEraseCfg = F;
  logic [NB-1:0] bankEraseEn = '0;
  logic [NI*4-1:0] infoEnCfg = '0, infoRdCfg = '0, infoProgCfg = '0, infoEraseCfg = '0;
  logic [1:0] errClr = 2'b00;
  logic respValid, respAllow, alertReq;
  logic [1:0] errCode;

  flash_perm_guard #(
    .NUM_REGIONS(NR), .NUM_BANKS(NB), .PAGE_W(PW), .INFO_TYPES(IT), .INFO_PAGES(IP)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqInfo(reqInfo),
    .reqBank(reqBank), .reqPage(reqPage), .reqInfoType(reqInfoType),
    .reqProgSel(reqProgSel), .progTypeEn(progTypeEn),
    .regEnCfg(regEnCfg), .regRdCfg(regRdCfg), .regProgCfg(regProgCfg),
    .regEraseCfg(regEraseCfg), .regStartCfg(regStartCfg), .regCountCfg(regCountCfg),
    .dfltRdCfg(dfltRdCfg), .dfltProgCfg(dfltProgCfg), .dfltEraseCfg(dfltEraseCfg),
    .bankEraseEn(bankEraseEn), .infoEnCfg(infoEnCfg), .infoRdCfg(infoRdCfg),
    .infoProgCfg(infoProgCfg), .infoEraseCfg(infoEraseCfg), .errClr(errClr),
    .respValid(respValid), .respAllow(respAllow), .errCode(errCode), .alertReq(alertReq)
  );

  int nTests = 0;
  int nFail = 0;
  logic [1:0] expErr = 2'b00;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setRegion(input int i, input logic [3:0] en, input int start, input int cnt,
                           input logic [3:0] rd, input logic [3:0] pg, input logic [3:0] er);
    regEnCfg[i*4 +: 4]    = en;
    regRdCfg[i*4 +: 4]    = rd;
    regProgCfg[i*4 +: 4]  = pg;
    regEraseCfg[i*4 +: 4] = er;
    regStartCfg[i*GW +: GW]         = GW'(start);
    regCountCfg[i*(GW+1) +: GW+1]   = (GW+1)'(cnt);
  endtask

  // Reference decision written from the requirements
  function automatic void model(input int op, input int part, input int bank, input int page,
                                input int itype, input int sel,
                                output bit allow, output bit sMp, output bit sPt);
    bit perm;
    bit found;
    logic [3:0] f;
    int k;
    int g;
    sMp = 0;
    sPt = 0;
    perm = 0;
    if (op == 1 && !progTypeEn[sel]) begin
      sPt = 1;                                   // R2
    end else begin
      if (op == 3) begin
        perm = bankEraseEn[bank];                // R7
      end else if (part == 1) begin              // R8
        if (page < IP && itype < IT) begin
          k = (bank * IT + itype) * IP + page;
          f = (op == 0) ? infoRdCfg[k*4 +: 4] : (op == 1) ? infoProgCfg[k*4 +: 4] :
              infoEraseCfg[k*4 +: 4];
          perm = (infoEnCfg[k*4 +: 4] == T) && (f == T);
        end
      end else begin                             // R4, R5, R6
        g = bank * 32 + page;
        found = 0;
        f = (op == 0) ? dfltRdCfg : (op == 1) ? dfltProgCfg : dfltEraseCfg;
        for (int i = 0; i < NR; i++) begin
          if (!found && regEnCfg[i*4 +: 4] == T &&
              g >= int'(regStartCfg[i*GW +: GW]) &&
              g < int'(regStartCfg[i*GW +: GW]) + int'(regCountCfg[i*(GW+1) +: GW+1])) begin
            found = 1;
            f = (op == 0) ? regRdCfg[i*4 +: 4] : (op == 1) ? regProgCfg[i*4 +: 4] :
                regEraseCfg[i*4 +: 4];
          end
        end
        perm = (f == T);                         // R3
      end
      sMp = !perm;                               // R9
    end
    allow = !(sMp || sPt);
  endfunction

  task automatic doReq(input int op, input int part, input int bank, input int page,
                       input int itype, input int sel, input logic [1:0] clr, input string tag);
    bit allow, sMp, sPt;
    logic [4:0] act, exp;
    @(negedge clk);
    reqValid    = 1'b1;
    reqOp       = 2'(op);
    reqInfo     = 1'(part);
    reqBank     = 1'(bank);
    reqPage     = PW'(page);
    reqInfoType = 1'(itype);
    reqProgSel  = 1'(sel);
    errClr      = clr;
    model(op, part, bank, page, itype, sel, allow, sMp, sPt);
    expErr = (expErr & ~clr) | {sPt, sMp};       // R10
    @(negedge clk);
    reqValid = 1'b0;
    errClr   = 2'b00;
    act = {respValid, respAllow, alertReq, errCode};
    exp = {1'b1, allow, !allow, expErr};         // R1, R11
    check(act == exp, tag, $sformatf("op%0d part%0d bank%0d page%0d type%0d sel%0d {valid,allow,alert,err}",
          op, part, bank, page, itype, sel), int'(act), int'(exp));
  endtask

  task automatic doIdle(input logic [1:0] clr, input string tag);
    logic [4:0] act, exp;
    @(negedge clk);
    reqValid = 1'b0;
    errClr   = clr;
    expErr   = expErr & ~clr;
    @(negedge clk);
    errClr = 2'b00;
    act = {respValid, respAllow, alertReq, errCode};
    exp = {3'b000, expErr};
    check(act == exp, tag, "idle {valid,allow,alert,err}", int'(act), int'(exp));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    // Region set: r0 4..7, r1 6..13 overlapping, r2 invalid enable, r3 60..63
    setRegion(0, T, 4, 4, T, T, F);
    setRegion(1, T, 6, 8, F, T, T);
    setRegion(2, 4'b1001, 20, 5, T, T, T);
    setRegion(3, T, 60, 4, T, F, T);
    for (int k = 0; k < NI; k++) begin
      infoEnCfg[k*4 +: 4]    = (k % 5 != 0) ? T : F;
      infoRdCfg[k*4 +: 4]    = (k % 2 == 1) ? T : 4'b0111;
      infoProgCfg[k*4 +: 4]  = (k % 3 != 0) ? T : F;
      infoEraseCfg[k*4 +: 4] = (k % 4 == 1) ? T : 4'b0000;
    end

    repeat (3) @(negedge clk);
    check({respValid, respAllow, alertReq, errCode} == 5'b0, "R1", "reset outputs",
          int'({respValid, respAllow, alertReq, errCode}), 0);
    rstN = 1'b1;

    // R4 R5 R6: every global page, read/program/page erase
    for (int op = 0; op < 3; op++)
      for (int g = 0; g < 64; g++)
        doReq(op, 0, g / 32, g % 32, 0, 0, (g % 4 == 0) ? 2'b11 : 2'b00, "R4");

    // R4: a zero-length region matches nothing
    setRegion(3, T, 60, 0, T, F, T);
    for (int g = 60; g < 64; g++) begin
      doReq(0, 0, 1, g % 32, 0, 0, 2'b11, "R4");
      doReq(2, 0, 1, g % 32, 0, 0, 2'b11, "R5");
    end
    setRegion(3, T, 60, 4, T, F, T);

    // R3: only 4'b0110 is true
    for (int v = 0; v < 16; v++) begin
      dfltRdCfg = 4'(v);
      doReq(0, 0, 0, 0, 0, 0, 2'b11, "R3");
    end
    dfltRdCfg = T;

    // R2: program-type enables against both selects, type error beats page error
    for (int en = 0; en < 4; en++) begin
      progTypeEn = 2'(en);
      for (int sel = 0; sel < 2; sel++) begin
        doReq(1, 0, 0, 0, 0, sel, 2'b11, "R2");
        doReq(1, 0, 0, 5, 0, sel, 2'b11, "R2");
        doReq(1, 0, 1, 30, 0, sel, 2'b11, "R2");
        doReq(1, 1, 0, 1, 0, sel, 2'b11, "R2");
      end
    end
    progTypeEn = 2'b11;

    // R7: bank erase gated only by its own bank bit
    for (int en = 0; en < 4; en++) begin
      bankEraseEn = 2'(en);
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 2; p++)
          doReq(3, p, b, 3, 0, 0, 2'b11, "R7");
    end

    // R8: every info entry and out-of-range pages
    for (int op = 0; op < 3; op++)
      for (int b = 0; b < 2; b++)
        for (int t = 0; t < 2; t++)
          for (int p = 0; p < 8; p++)
            doReq(op, 1, b, p, t, 0, 2'b11, "R8");

    // R9 R10 R11: stickiness, partial clear, set-wins-over-clear
    doIdle(2'b11, "R10");
    doReq(0, 0, 0, 8, 0, 0, 2'b00, "R9");        // r1 read false -> protection error
    progTypeEn = 2'b01;
    doReq(1, 0, 0, 0, 0, 1, 2'b00, "R11");       // repair disabled -> type error
    progTypeEn = 2'b11;
    doReq(0, 0, 0, 0, 0, 0, 2'b00, "R10");       // allowed, both bits stay set
    doIdle(2'b00, "R10");
    doIdle(2'b01, "R10");
    doReq(0, 0, 0, 8, 0, 0, 2'b01, "R10");       // set and clear together: set wins
    doIdle(2'b11, "R1");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule